// File: doc/BRIEF.md
# PMBus Paged Command Validator

This block sits behind a front end that has already turned SMBus traffic into single byte-level command accesses. Each access carries a command code, a read/write flag and, for writes, one data byte. The block holds the PAGE register, which picks one of `NUM_RAILS` output rails. It checks every command against the selected rail. Legal per-rail commands go out as one-cycle register strobes tagged with the rail index. Commands it handles itself (PAGE, CLEAR_FAULTS, the shared input status and the communication-fault register) are answered locally.

Each rail is either ADC-monitored or driven by an external power-good input, as set by the `ADC_MASK` parameter. On a rail without ADC monitoring, telemetry reads and voltage-threshold commands are refused. The input-side status byte exists once and is the same on every page. Refused commands and refused page values are recorded in the communication-fault register. Any bit set in that register raises a fault-summary output.

Every access gets exactly one response. The response appears one clock after the command is accepted, in the same cycle as any downstream strobe.

Top module: `pmbus_page_validator`

## Requirements
- R1: After a synchronous reset the selected page is 0, the communication-fault register reads 0x00, the input status reads 0x00 and `fault_o` is low.
- R2: A PAGE write (code 0x00) with a value from 0 to NUM_RAILS-1 selects that rail. Every later forwarded access carries it on `dn_rail`. A PAGE read returns the current page.
- R3: A PAGE write of 0xFF is refused and the previous page stays selected.
- R4: A PAGE write of any value at or above NUM_RAILS is refused. Bit 6 (invalid data) of the communication-fault register is set and nothing is forwarded.
- R5: A code outside the known set is refused. The known set is 0x00, 0x03, 0x7C, 0x7E and the per-rail codes 0x01, 0x79, 0x7A, 0x40–0x44 and 0x8B. A read of CLEAR_FAULTS (0x03) is also refused. A refused command sets bit 7 (invalid or unsupported command) of the communication-fault register (code 0x7E), produces no `dn_req`, and a refused read returns 0xFF.
- R6: Codes 0x40–0x44 and 0x8B are refused, as in R5, when the selected rail's bit in `ADC_MASK` is 0. The same codes are forwarded when that bit is 1.
- R7: Input status (code 0x7C) collects bits from `vin_event_i` and is one shared copy. Every page reads the same value.
- R8: A CLEAR_FAULTS write clears the communication-fault register and the input status. It also pulses `rail_clr_o` for one cycle with `rail_clr_idx_o` equal to the current page.
- R9: Writes to codes 0x7C and 0x7E clear the bits that are set in the data byte (write-one-to-clear). The effect is the same whichever page is selected.
- R10: An input event arriving in the same cycle as a clear, or as a write-one-to-clear, of the input status is kept.
- R11: `fault_o` is high exactly when the communication-fault register is non-zero.
- R12: A forwarded access raises `dn_req` for one cycle, one clock after the command is accepted. `dn_we`, `dn_code` and `dn_wdata` match the command. A forwarded read returns `dn_rdata` on `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One access offered this cycle |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_code | input | 8 | Command code |
| cmd_wdata | input | 8 | Write data byte |
| vin_event_i | input | 8 | Input-side fault events, one bit each |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 8 | Read data for that access |
| dn_req | output | 1 | Downstream register strobe |
| dn_we | output | 1 | Downstream write flag |
| dn_rail | output | RW | Rail index of the strobe |
| dn_code | output | 8 | Command code forwarded |
| dn_wdata | output | 8 | Write data forwarded |
| dn_rdata | input | 8 | Read data from the rail register space |
| rail_clr_o | output | 1 | Clear pulse for one rail's status |
| rail_clr_idx_o | output | RW | Rail that is cleared |
| fault_o | output | 1 | Communication-fault summary |

## Verification
Two functions can collide in one cycle: a new input-side event arriving from the monitors, and a command that clears the input status. The command is either CLEAR_FAULTS or a write-one-to-clear of code 0x7C. The bench drives the event bit and the clearing command in the same clock. It then reads the input status back through code 0x7C and expects the new bit to be present while older bits are gone. It also checks that a refused PAGE value and a later CLEAR_FAULTS each leave the fault register and `fault_o` in the states R4 and R8 call for.

// File: rtl/pmv_pkg.sv
package pmv_pkg;

    localparam logic [7:0] CODE_PAGE     = 8'h00;
    localparam logic [7:0] CODE_CLEAR    = 8'h03;
    localparam logic [7:0] CODE_STAT_IN  = 8'h7C;
    localparam logic [7:0] CODE_STAT_CML = 8'h7E;
    localparam logic [7:0] REFUSED_DATA  = 8'hFF;

    localparam int CML_BAD_CMD  = 7;
    localparam int CML_BAD_DATA = 6;

    typedef enum logic [2:0] {
        K_PAGE,
        K_CLEAR,
        K_STAT_IN,
        K_STAT_CML,
        K_FWD,
        K_BAD
    } cmd_kind_e;

    // Per-rail codes passed to the rail register space.
    function automatic logic is_rail_code(input logic [7:0] c);
        return (c inside {8'h01, 8'h79, 8'h7A, 8'h8B, [8'h40:8'h44]});
    endfunction

    // Codes that need an ADC behind the rail: telemetry and thresholds.
    function automatic logic needs_adc(input logic [7:0] c);
        return (c == 8'h8B) || (c inside {[8'h40:8'h44]});
    endfunction

endpackage

// File: rtl/pmv_decode.sv
module pmv_decode
    import pmv_pkg::*;
#(
    parameter int                    NUM_RAILS = 6,
    parameter int                    RW        = 3,
    parameter logic [NUM_RAILS-1:0]  ADC_MASK  = '1
) (
    input  logic [7:0]    code,
    input  logic          we,
    input  logic [RW-1:0] page,
    output cmd_kind_e     kind
);

    logic rail_has_adc;

    always_comb begin
        rail_has_adc = ADC_MASK[page];
    end

    always_comb begin
        unique case (code)
            CODE_PAGE:     kind = K_PAGE;
            CODE_CLEAR:    kind = we ? K_CLEAR : K_BAD;
            CODE_STAT_IN:  kind = K_STAT_IN;
            CODE_STAT_CML: kind = K_STAT_CML;
            default: begin
                if (is_rail_code(code) && (!needs_adc(code) || rail_has_adc))
                    kind = K_FWD;
                else
                    kind = K_BAD;
            end
        endcase
    end

endmodule

// File: rtl/pmv_page.sv
module pmv_page #(
    parameter int NUM_RAILS = 6,
    parameter int RW        = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wdata,
    output logic [RW-1:0] page,
    output logic          reject
);

    localparam logic [7:0] LAST_PAGE = 8'(NUM_RAILS - 1);

    assign reject = wr_en && (wdata > LAST_PAGE);

    always_ff @(posedge clk) begin
        if (rst)
            page <= '0;
        else if (wr_en && !reject)
            page <= wdata[RW-1:0];
    end

    // R4
    page_range_chk: assert property (@(posedge clk) disable iff (rst)
        {{(8-RW){1'b0}}, page} <= LAST_PAGE);

    // R3
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata == 8'hFF) |=> $stable(page));

endmodule

// File: rtl/pmv_status.sv
module pmv_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       bad_cmd,
    input  logic       bad_data,
    input  logic       clear_all,
    input  logic       cml_w1c,
    input  logic       in_w1c,
    input  logic [7:0] w1c_mask,
    input  logic [7:0] vin_event,
    output logic [7:0] cml,
    output logic [7:0] stat_in
);

    logic [7:0] cml_nx;
    logic [7:0] in_nx;

    always_comb begin
        cml_nx = cml;
        if (clear_all)
            cml_nx = '0;
        else if (cml_w1c)
            cml_nx = cml & ~w1c_mask;
        cml_nx[7] = cml_nx[7] | bad_cmd;
        cml_nx[6] = cml_nx[6] | bad_data;
    end

    always_comb begin
        in_nx = stat_in;
        if (clear_all)
            in_nx = '0;
        else if (in_w1c)
            in_nx = stat_in & ~w1c_mask;
        in_nx = in_nx | vin_event;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cml     <= '0;
            stat_in <= '0;
        end else begin
            cml     <= cml_nx;
            stat_in <= in_nx;
        end
    end

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_all && vin_event == 8'h00) |=> (stat_in == 8'h00 && cml == 8'h00));

    // R10
    event_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (vin_event != 8'h00) |=> ((stat_in & $past(vin_event)) == $past(vin_event)));

endmodule

// File: rtl/pmbus_page_validator.sv
module pmbus_page_validator
    import pmv_pkg::*;
#(
    parameter int                    NUM_RAILS = 6,
    parameter logic [NUM_RAILS-1:0]  ADC_MASK  = 6'b110101,
    localparam int                   RW        = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_code,
    input  logic [7:0]    cmd_wdata,
    input  logic [7:0]    vin_event_i,
    output logic          rsp_valid,
    output logic [7:0]    rsp_rdata,
    output logic          dn_req,
    output logic          dn_we,
    output logic [RW-1:0] dn_rail,
    output logic [7:0]    dn_code,
    output logic [7:0]    dn_wdata,
    input  logic [7:0]    dn_rdata,
    output logic          rail_clr_o,
    output logic [RW-1:0] rail_clr_idx_o,
    output logic          fault_o
);

    cmd_kind_e     kind;
    logic [RW-1:0] page;
    logic          page_reject;
    logic [7:0]    cml;
    logic [7:0]    stat_in;
    logic          rsp_from_dn;
    logic [7:0]    rsp_local;
    logic [7:0]    local_rd;

    logic is_page_wr, is_clear, is_bad, cml_w1c, in_w1c, is_fwd;

    pmv_decode #(.NUM_RAILS(NUM_RAILS), .RW(RW), .ADC_MASK(ADC_MASK)) u_dec (
        .code (cmd_code),
        .we   (cmd_we),
        .page (page),
        .kind (kind)
    );

    always_comb begin
        is_page_wr = cmd_valid && kind == K_PAGE && cmd_we;
        is_clear   = cmd_valid && kind == K_CLEAR;
        is_bad     = cmd_valid && kind == K_BAD;
        is_fwd     = cmd_valid && kind == K_FWD;
        cml_w1c    = cmd_valid && kind == K_STAT_CML && cmd_we;
        in_w1c     = cmd_valid && kind == K_STAT_IN && cmd_we;
    end

    pmv_page #(.NUM_RAILS(NUM_RAILS), .RW(RW)) u_page (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (is_page_wr),
        .wdata  (cmd_wdata),
        .page   (page),
        .reject (page_reject)
    );

    pmv_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .bad_cmd   (is_bad),
        .bad_data  (page_reject),
        .clear_all (is_clear),
        .cml_w1c   (cml_w1c),
        .in_w1c    (in_w1c),
        .w1c_mask  (cmd_wdata),
        .vin_event (vin_event_i),
        .cml       (cml),
        .stat_in   (stat_in)
    );

    // Data returned for accesses answered locally.
    always_comb begin
        local_rd = 8'h00;
        if (!cmd_we) begin
            unique case (kind)
                K_PAGE:     local_rd = {{(8-RW){1'b0}}, page};
                K_STAT_IN:  local_rd = stat_in;
                K_STAT_CML: local_rd = cml;
                K_BAD:      local_rd = REFUSED_DATA;
                default:    local_rd = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_from_dn    <= 1'b0;
            rsp_local      <= 8'h00;
            dn_req         <= 1'b0;
            dn_we          <= 1'b0;
            dn_rail        <= '0;
            dn_code        <= 8'h00;
            dn_wdata       <= 8'h00;
            rail_clr_o     <= 1'b0;
            rail_clr_idx_o <= '0;
        end else begin
            rsp_valid   <= cmd_valid;
            rsp_from_dn <= is_fwd && !cmd_we;
            rsp_local   <= local_rd;
            dn_req      <= is_fwd;
            rail_clr_o  <= is_clear;
            if (is_fwd) begin
                dn_we    <= cmd_we;
                dn_rail  <= page;
                dn_code  <= cmd_code;
                dn_wdata <= cmd_wdata;
            end
            if (is_clear)
                rail_clr_idx_o <= page;
        end
    end

    assign rsp_rdata = rsp_from_dn ? dn_rdata : rsp_local;
    assign fault_o   = |cml;

    // R5
    no_bad_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind == K_BAD && !cmd_we) |=> (!dn_req && rsp_rdata == 8'hFF));

    // R11
    summary_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind == K_BAD) |=> fault_o);

    // R2
    dn_rail_chk: assert property (@(posedge clk) disable iff (rst)
        dn_req |-> (dn_rail == page));

    // R12
    dn_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && kind == K_FWD) |=> !dn_req);

endmodule

// File: tb/sim_pmbus_page_validator.sv
module sim_pmbus_page_validator;

    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_we = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic [7:0]    cmd_wdata = 8'h00;
    logic [7:0]    vin_event_i = 8'h00;
    logic          rsp_valid;
    logic [7:0]    rsp_rdata;
    logic          dn_req, dn_we;
    logic [RW-1:0] dn_rail;
    logic [7:0]    dn_code, dn_wdata, dn_rdata;
    logic          rail_clr_o;
    logic [RW-1:0] rail_clr_idx_o;
    logic          fault_o;

    int n_checks = 0;
    int n_fail = 0;

    // Rail register space model: rail*16 + low nibble of code.
    assign dn_rdata = {1'b0, dn_rail, dn_code[3:0]};

    always #4 clk = ~clk;

    pmbus_page_validator u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
        .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .vin_event_i(vin_event_i),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dn_req(dn_req),
        .dn_we(dn_we), .dn_rail(dn_rail), .dn_code(dn_code),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .rail_clr_o(rail_clr_o),
        .rail_clr_idx_o(rail_clr_idx_o), .fault_o(fault_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Offers one access; returns outputs sampled one clock later.
    task automatic access(input logic we, input logic [7:0] code, input logic [7:0] data,
                          input logic [7:0] ev,
                          output logic [7:0] rd, output logic req, output logic clr);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_we = we; cmd_code = code; cmd_wdata = data; vin_event_i = ev;
        @(negedge clk);
        cmd_valid = 1'b0; vin_event_i = 8'h00;
        rd = rsp_rdata; req = dn_req; clr = rail_clr_o;
    endtask

    function automatic logic [7:0] read_of(input logic [7:0] d);
        return d;
    endfunction

    task automatic rd_reg(input logic [7:0] code, output logic [7:0] rd);
        logic q, c;
        access(1'b0, code, 8'h00, 8'h00, rd, q, c);
    endtask

    task automatic wr_reg(input logic [7:0] code, input logic [7:0] data);
        logic [7:0] r; logic q, c;
        access(1'b1, code, data, 8'h00, r, q, c);
    endtask

    task automatic t_reset;
        logic [7:0] r;
        chk("R1 fault_o", fault_o, 0);
        rd_reg(8'h00, r); chk("R1 page", r, 0);
        rd_reg(8'h7E, r); chk("R1 cml", r, 0);
        rd_reg(8'h7C, r); chk("R1 stat_in", r, 0);
    endtask

    task automatic t_page_select;
        logic [7:0] r; logic q, c;
        wr_reg(8'h00, 8'd2);
        rd_reg(8'h00, r); chk("R2 page read", r, 2);
        access(1'b0, 8'h8B, 8'h00, 8'h00, r, q, c);
        chk("R2 fwd req", q, 1); chk("R2 dn_rail", dn_rail, 2);
        chk("R12 fwd read data", r, 8'h2B);
        access(1'b1, 8'h01, 8'h5A, 8'h00, r, q, c);
        chk("R12 wr req", q, 1); chk("R12 dn_we", dn_we, 1);
        chk("R12 dn_wdata", dn_wdata, 8'h5A); chk("R12 dn_code", dn_code, 8'h01);
        @(negedge clk); chk("R12 single pulse", dn_req, 0);
    endtask

    task automatic t_page_reject;
        logic [7:0] r; logic q, c;
        access(1'b1, 8'h00, 8'hFF, 8'h00, r, q, c);
        chk("R3 no fwd", q, 0);
        rd_reg(8'h00, r); chk("R3 page kept", r, 2);
        rd_reg(8'h7E, r); chk("R3 bit6", r, 8'h40);
        chk("R11 fault_o high", fault_o, 1);
        wr_reg(8'h7E, 8'h40);
        chk("R11 fault_o low", fault_o, 0);
        access(1'b1, 8'h00, 8'd6, 8'h00, r, q, c);
        chk("R4 no fwd", q, 0);
        rd_reg(8'h00, r); chk("R4 page kept", r, 2);
        rd_reg(8'h7E, r); chk("R4 bit6", r, 8'h40);
        wr_reg(8'h00, 8'd5);
        rd_reg(8'h00, r); chk("R4 last page accepted", r, 5);
        wr_reg(8'h7E, 8'hFF);
    endtask

    task automatic t_bad_cmd;
        logic [7:0] r; logic q, c;
        access(1'b0, 8'h55, 8'h00, 8'h00, r, q, c);
        chk("R5 unknown no req", q, 0); chk("R5 unknown rdata", r, 8'hFF);
        rd_reg(8'h7E, r); chk("R5 bit7", r, 8'h80);
        wr_reg(8'h7E, 8'h80);
        access(1'b0, 8'h03, 8'h00, 8'h00, r, q, c);
        chk("R5 clear read refused", r, 8'hFF);
        rd_reg(8'h7E, r); chk("R5 bit7 again", r, 8'h80);
        wr_reg(8'h7E, 8'h80);
    endtask

    task automatic t_adc_filter;
        logic [7:0] r; logic q, c;
        wr_reg(8'h00, 8'd1);
        access(1'b0, 8'h8B, 8'h00, 8'h00, r, q, c);
        chk("R6 rail1 telemetry refused", q, 0); chk("R6 rail1 rdata", r, 8'hFF);
        access(1'b1, 8'h40, 8'h12, 8'h00, r, q, c);
        chk("R6 rail1 threshold refused", q, 0);
        rd_reg(8'h7E, r); chk("R6 bit7", r, 8'h80);
        access(1'b0, 8'h79, 8'h00, 8'h00, r, q, c);
        chk("R6 rail1 status allowed", q, 1); chk("R6 rail1 rdata", r, 8'h19);
        wr_reg(8'h00, 8'd4);
        access(1'b1, 8'h44, 8'h33, 8'h00, r, q, c);
        chk("R6 rail4 threshold forwarded", q, 1); chk("R6 rail4 index", dn_rail, 4);
        wr_reg(8'h7E, 8'hFF);
    endtask

    task automatic t_shared_input;
        logic [7:0] r; logic q, c;
        access(1'b0, 8'h79, 8'h00, 8'h21, r, q, c);
        wr_reg(8'h00, 8'd0);
        rd_reg(8'h7C, r); chk("R7 page0 stat_in", r, 8'h21);
        wr_reg(8'h00, 8'd3);
        rd_reg(8'h7C, r); chk("R7 page3 stat_in", r, 8'h21);
        wr_reg(8'h7C, 8'h01);
        wr_reg(8'h00, 8'd0);
        rd_reg(8'h7C, r); chk("R9 w1c seen on page0", r, 8'h20);
        access(1'b0, 8'h66, 8'h00, 8'h00, r, q, c);
        wr_reg(8'h00, 8'd5);
        wr_reg(8'h7E, 8'h80);
        chk("R9 cml w1c fault_o", fault_o, 0);
    endtask

    task automatic t_clear;
        logic [7:0] r; logic q, c;
        access(1'b0, 8'h55, 8'h00, 8'h04, r, q, c);
        wr_reg(8'h00, 8'd3);
        access(1'b1, 8'h03, 8'h00, 8'h00, r, q, c);
        chk("R8 rail_clr pulse", c, 1); chk("R8 rail_clr idx", rail_clr_idx_o, 3);
        chk("R8 no fwd", q, 0);
        rd_reg(8'h7E, r); chk("R8 cml cleared", r, 0);
        rd_reg(8'h7C, r); chk("R8 stat_in cleared", r, 0);
        chk("R8 fault_o low", fault_o, 0);
    endtask

    task automatic t_collide;
        logic [7:0] r; logic q, c;
        access(1'b0, 8'h79, 8'h00, 8'h03, r, q, c);
        access(1'b1, 8'h03, 8'h00, 8'h10, r, q, c);
        rd_reg(8'h7C, r); chk("R10 event survives clear", r, 8'h10);
        access(1'b1, 8'h7C, 8'h10, 8'h10, r, q, c);
        rd_reg(8'h7C, r); chk("R10 event survives w1c", r, 8'h10);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_page_select;
        t_page_reject;
        t_bad_cmd;
        t_adc_filter;
        t_shared_input;
        t_clear;
        t_collide;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule